// File: doc/BRIEF.md
# Double-Buffered PWM Timer

This block is a 16-bit up-counter that turns a stream of prescaled clock ticks into a pulse-width-modulated output. A period compare value sets how many ticks make one output period. A duty compare value sets how many of those ticks the output stays high. A set/clear flip-flop drives the output. It is set when the counter wraps and cleared after the duty match. Each wrap also raises a one-clock interrupt pulse.

Both compare values can be double-buffered. In that mode the counter is compared against a shadow copy of each value, not the written value. Each shadow takes the written value only when the counter reaches the shadow's current content. A new period or duty written in the middle of a period therefore never cuts that period short. Software first writes the compare values and then strobes each shadow's own sync address once. After that it sets the run bit. With double buffering off, the compare logic uses the written values directly.

Top module: `pwm_dbuf_timer`

## Requirements
- R1: Writes are whole 16-bit words selected by `wr_addr`: 0 = mode (bit 0 run, bit 1 double-buffer), 1 = period value P, 2 = duty value D, 3 = period shadow sync, 4 = duty shadow sync. Writes to addresses 5 to 7 have no effect.
- R2: While the run bit is clear, the counter and the output flip-flop are held at 0 and no interrupt pulse is produced.
- R3: The counter wraps after reaching the active period compare, so a period lasts P+1 ticks. Each wrap gives `period_irq` a pulse one clock wide, starting in the clock after the wrapping tick.
- R4: The output is set at the wrap and cleared on the tick after the counter equals the active duty compare, so it is high for D+1 of every P+1 ticks. With P=4 and D=1 this gives 2 high ticks out of 5. Valid settings are P from 1 to 0xFFFE and D from 0 to P-1.
- R5: In double-buffer mode, the period shadow copies P only on the tick where the counter equals the shadow. A period already under way keeps its old length.
- R6: In double-buffer mode, the duty shadow copies D only on the tick where the counter equals the shadow. The high time changes from the first period in which that match falls after the write.
- R7: A write of any data to a sync address copies the current P or D into that shadow. With both shadows synced, the first wrap after setting the run bit comes P+1 ticks after counting starts, and the counter starts with the first tick seen one clock after the mode write.
- R8: The counter advances only on clocks where `tick` is high. With a tick every k clocks, the period is k·(P+1) clocks and the high time is k·(D+1) clocks.
- R9: With double buffering off, a new P or D applies within the current period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 16 | Write data |
| tick | input | 1 | Prescaled count enable |
| pwm_out | output | 1 | PWM output from the set/clear flip-flop |
| period_irq | output | 1 | One-clock pulse after each wrap |

## Verification
A stale or wrong period shadow shows up as a wrong spacing of `period_irq` pulses, starting with the first wrap after the fault. A stale or wrong duty shadow shows up as a wrong high time within the very next period. A shadow that loads too early or too late shifts the first changed period by exactly one period, so the bench measures period by period across a mid-period write. A stuck counter or flip-flop while stopped shows up at once as output activity with the run bit clear.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

    localparam int unsigned ADDR_W    = 3;
    localparam int unsigned N_CMP     = 2;
    localparam int unsigned CMP_PER   = 0;
    localparam int unsigned CMP_DUTY  = 1;
    localparam int unsigned RUN_BIT   = 0;
    localparam int unsigned DBUF_BIT  = 1;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_MODE   = 3'd0,
        ADDR_PER    = 3'd1,
        ADDR_DUTY   = 3'd2,
        ADDR_SYNC_P = 3'd3,
        ADDR_SYNC_D = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic dbuf;
        logic run;
    } mode_t;

    typedef struct packed {
        logic wrap;
        logic duty;
    } match_t;

    function automatic mode_t unpack_mode(input logic [1:0] bits);
        mode_t m;
        m.run  = bits[RUN_BIT];
        m.dbuf = bits[DBUF_BIT];
        return m;
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_tmr_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [W-1:0]             wr_data,
    output mode_t                    mode_q,
    output logic [W-1:0]             per_q,
    output logic [W-1:0]             duty_q,
    output logic                     sync_per,
    output logic                     sync_duty
);

    reg_addr_e sel;
    assign sel = reg_addr_e'(wr_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            per_q  <= '0;
            duty_q <= '0;
        end else if (wr_en) begin
            case (sel)
                ADDR_MODE: mode_q <= unpack_mode(wr_data[1:0]);
                ADDR_PER:  per_q  <= wr_data;
                ADDR_DUTY: duty_q <= wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        sync_per  = wr_en && (sel == ADDR_SYNC_P);
        sync_duty = wr_en && (sel == ADDR_SYNC_D);
    end

endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         dbuf,
    input  logic         sync,
    input  logic         hit,
    input  logic [W-1:0] src,
    output logic [W-1:0] shd_q,
    output logic [W-1:0] cmp
);

    always_ff @(posedge clk) begin
        if (rst)
            shd_q <= '0;
        else if (sync || hit)
            shd_q <= src;
    end

    assign cmp = dbuf ? shd_q : src;

endmodule

// File: rtl/pwm_core.sv
module pwm_core
    import pwm_tmr_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] cmp_per,
    input  logic [W-1:0] cmp_duty,
    output match_t       hit,
    output logic [W-1:0] cnt_q,
    output logic         ff_q,
    output logic         irq_q
);

    logic step;

    always_comb begin
        step     = run && tick;
        hit.wrap = step && (cnt_q == cmp_per);
        hit.duty = step && (cnt_q == cmp_duty);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            ff_q  <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= hit.wrap;
            if (step)
                cnt_q <= hit.wrap ? '0 : cnt_q + W'(1);
            if (hit.wrap)
                ff_q <= 1'b1;
            else if (hit.duty)
                ff_q <= 1'b0;
        end
    end

endmodule

// File: rtl/pwm_dbuf_timer.sv
module pwm_dbuf_timer
    import pwm_tmr_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [2:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         tick,
    output logic         pwm_out,
    output logic         period_irq
);

    mode_t        mode_q;
    logic [W-1:0] per_q, duty_q;
    logic         sync_per, sync_duty;
    match_t       hit;
    logic [W-1:0] cnt_q;

    logic [W-1:0] src_v  [N_CMP];
    logic [W-1:0] shd_v  [N_CMP];
    logic [W-1:0] cmp_v  [N_CMP];
    logic         sync_v [N_CMP];
    logic         hit_v  [N_CMP];

    pwm_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .mode_q    (mode_q),
        .per_q     (per_q),
        .duty_q    (duty_q),
        .sync_per  (sync_per),
        .sync_duty (sync_duty)
    );

    always_comb begin
        src_v[CMP_PER]   = per_q;
        src_v[CMP_DUTY]  = duty_q;
        sync_v[CMP_PER]  = sync_per;
        sync_v[CMP_DUTY] = sync_duty;
        hit_v[CMP_PER]   = hit.wrap;
        hit_v[CMP_DUTY]  = hit.duty;
    end

    for (genvar g = 0; g < N_CMP; g++) begin : g_shadow
        pwm_shadow #(.W(W)) u_shadow (
            .clk   (clk),
            .rst   (rst),
            .dbuf  (mode_q.dbuf),
            .sync  (sync_v[g]),
            .hit   (hit_v[g]),
            .src   (src_v[g]),
            .shd_q (shd_v[g]),
            .cmp   (cmp_v[g])
        );
    end

    pwm_core #(.W(W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .run      (mode_q.run),
        .tick     (tick),
        .cmp_per  (cmp_v[CMP_PER]),
        .cmp_duty (cmp_v[CMP_DUTY]),
        .hit      (hit),
        .cnt_q    (cnt_q),
        .ff_q     (pwm_out),
        .irq_q    (period_irq)
    );

endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         run,
    input logic         tick,
    input logic         wrap,
    input logic         duty,
    input logic         sync_p,
    input logic         sync_d,
    input logic [W-1:0] per_val,
    input logic [W-1:0] cnt,
    input logic [W-1:0] shd_p,
    input logic [W-1:0] shd_d,
    input logic         pwm_out,
    input logic         period_irq
);

    AST_IDLE_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0 && !pwm_out && !period_irq)); // R2
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt == '0 && period_irq && pwm_out)); // R3
    AST_DUTY_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (duty && !wrap) |=> !pwm_out); // R4
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !wrap) |=> cnt == $past(cnt) + W'(1)); // R8
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> $stable(cnt)); // R8
    AST_PER_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wrap && !sync_p) |=> $stable(shd_p)); // R5
    AST_DUTY_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!duty && !sync_d) |=> $stable(shd_d)); // R6
    AST_SYNC_LOADS: assert property (@(posedge clk) disable iff (rst)
        sync_p |=> shd_p == $past(per_val)); // R7

endmodule

bind pwm_dbuf_timer pwm_timer_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .run        (mode_q.run),
    .tick       (tick),
    .wrap       (hit.wrap),
    .duty       (hit.duty),
    .sync_p     (sync_per),
    .sync_d     (sync_duty),
    .per_val    (per_q),
    .cnt        (cnt_q),
    .shd_p      (shd_v[0]),
    .shd_d      (shd_v[1]),
    .pwm_out    (pwm_out),
    .period_irq (period_irq)
);

// File: tb/test_pwm_dbuf_timer.sv
module test_pwm_dbuf_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        tick = 1'b0;
    logic        pwm_out, period_irq;

    int n_chk  = 0;
    int n_fail = 0;
    int tick_div = 1;
    int tcnt = 0;

    always #2.5 clk = ~clk;

    pwm_dbuf_timer i_pwm_dbuf_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tick(tick), .pwm_out(pwm_out),
        .period_irq(period_irq)
    );

    always @(negedge clk) begin
        if (tcnt + 1 >= tick_div) begin
            tcnt <= 0;
            tick <= 1'b1;
        end else begin
            tcnt <= tcnt + 1;
            tick <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // called at a negedge; returns at the next negedge with the strobe removed
    task automatic wr(input int addr, input int data);
        wr_en = 1'b1;
        wr_addr = 3'(addr);
        wr_data = 16'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_irq();
        do @(negedge clk); while (!period_irq);
    endtask

    // from an irq sample, count samples up to the next irq sample
    task automatic measure(inout int len, inout int high);
        forever begin
            @(negedge clk);
            if (period_irq) break;
            len++;
            high += int'(pwm_out);
        end
    endtask

    task automatic setup(input int p, input int d, input int mode);
        wr(0, 0);
        wr(1, p);
        wr(2, d);
        wr(3, 16'hFFFF);
        wr(4, 16'h0000);
        wr(0, mode);
    endtask

    task automatic check_period(input int exp_len, input int exp_high, input string tag);
        int len = 1, high = 1;
        measure(len, high);
        check(len == exp_len, {tag, " period"}, len, exp_len);
        check(high == exp_high, {tag, " high"}, high, exp_high);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int len, high, first;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state (R2)
        check(pwm_out == 1'b0, "R2 reset pwm", int'(pwm_out), 0);
        check(period_irq == 1'b0, "R2 reset irq", int'(period_irq), 0);

        // start latency after shadow sync (R7): irq at sample P+2
        wr(1, 4); wr(2, 1); wr(3, 16'h1234); wr(4, 16'hFFFF);
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 16'h0003;
        first = 0; high = 0;
        for (int i = 1; i <= 20; i++) begin
            @(negedge clk);
            wr_en = 1'b0;
            if (period_irq) begin first = i; break; end
            high += int'(pwm_out);
        end
        check(first == 6, "R7 first wrap sample", first, 6);
        check(high == 0, "R7 output low before first wrap", high, 0);
        // 2/5 waveform (R4, R3)
        check_period(5, 2, "R4 two-of-five");
        check_period(5, 2, "R3 repeat");

        // ignored addresses (R1)
        wr(5, 16'h0000); wr(6, 16'h0001); wr(7, 16'hFFFF);
        wait_irq();
        check_period(5, 2, "R1 unused addresses");

        // exhaustive small sweep (R3, R4), both buffer modes
        for (int db = 0; db < 2; db++)
            for (int p = 1; p <= 7; p++)
                for (int d = 0; d < p; d++) begin
                    setup(p, d, 1 + 2 * db);
                    wait_irq();
                    check_period(p + 1, d + 1, db ? "R3 R4 sweep dbuf" : "R3 R4 sweep direct");
                    check_period(p + 1, d + 1, "R4 sweep repeat");
                end

        // mid-period change in double-buffer mode (R5, R6)
        setup(4, 1, 3);
        wait_irq();
        len = 1; high = 1;
        wr_en = 1'b1; wr_addr = 3'd2; wr_data = 16'd3;
        @(negedge clk);
        len++; high += int'(pwm_out);
        wr_addr = 3'd1; wr_data = 16'd7;
        @(negedge clk);
        len++; high += int'(pwm_out);
        wr_en = 1'b0;
        measure(len, high);
        check(len == 5, "R5 old period kept", len, 5);
        check(high == 2, "R6 duty reload at its match", high, 2);
        check_period(8, 4, "R5 R6 new values after reload");

        // same change with buffering off applies at once (R9)
        setup(4, 1, 1);
        wait_irq();
        len = 1; high = 1;
        wr_en = 1'b1; wr_addr = 3'd2; wr_data = 16'd3;
        @(negedge clk);
        len++; high += int'(pwm_out);
        wr_addr = 3'd1; wr_data = 16'd7;
        @(negedge clk);
        len++; high += int'(pwm_out);
        wr_en = 1'b0;
        measure(len, high);
        check(len == 8, "R9 direct period", len, 8);
        check(high == 4, "R9 direct duty", high, 4);

        // sparse ticks (R8)
        tick_div = 3;
        setup(4, 1, 3);
        wait_irq();
        check_period(15, 6, "R8 tick every 3");
        tick_div = 1;

        // stop holds everything low (R2)
        setup(4, 1, 3);
        wait_irq();
        wr(0, 2);
        high = 0; first = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            high += int'(pwm_out);
            first += int'(period_irq);
        end
        check(high == 0, "R2 stopped output", high, 0);
        check(first == 0, "R2 stopped irq", first, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule